// File: doc/BRIEF.md
# Virtual-to-Physical Page Translator

This block turns a processor virtual address into a physical address. The low bits of the address are the byte position inside a page and are never changed. The high bits are the virtual page number. That number is compared in parallel against every line of a small fully associative lookaside store. When a line matches, its physical page number is placed in front of the unchanged offset, and the result is returned one cycle after the request.

When no line matches, the block stops accepting requests. It sends a walk request carrying the virtual page number to an external page-table engine and waits for that engine's reply. A reply that carries a mapping is written into the store and also returned as the translation. A reply that carries no mapping is returned as a page fault, with a zero address, and nothing is written into the store.

Refills go to the lowest-numbered empty line. When every line is full, a rotating pointer chooses which line to overwrite. A single invalidate-all input empties the whole store in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: The physical address is the physical page number followed by the request's low 12 offset bits, which pass through unchanged (4 KiB pages, 32-bit addresses).
- R2: A request whose virtual page number matches a valid line raises rsp_valid_o with the translated address in the cycle after acceptance, and no walk request is issued.
- R3: A request that misses raises walk_req_valid_o with walk_req_vpn_o equal to address bits 31:12 in the cycle after acceptance. Both are held, and req_ready_o stays low, until walk_rsp_valid_i is seen.
- R4: A walk reply with walk_rsp_mapped_i=1 returns rsp_valid_o=1, rsp_fault_o=0 and {walk_rsp_ppn_i, offset} in the next cycle, and installs the line so that a later request to the same page hits. req_ready_o is high again in that same cycle.
- R5: A walk reply with walk_rsp_mapped_i=0 returns rsp_valid_o=1, rsp_fault_o=1 and rsp_paddr_o=0 in the next cycle, and installs nothing, so a repeated request misses again.
- R6: After reset all lines are invalid, req_ready_o=1, and rsp_valid_o, rsp_fault_o and walk_req_valid_o are 0.
- R7: A refill writes the lowest-indexed invalid line.
- R8: When all 8 lines are valid, a refill overwrites the line named by a rotating pointer. The pointer starts at line 0 after reset and advances by one, wrapping, after each such refill.
- R9: flush_i=1 on a clock edge clears every valid bit. A refill on that same edge is dropped, but its translation is still returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_vaddr_i | input | 32 | Virtual address |
| rsp_valid_o | output | 1 | One-cycle result strobe |
| rsp_paddr_o | output | 32 | Physical address, zero on fault |
| rsp_fault_o | output | 1 | Page fault: no mapping exists |
| walk_req_valid_o | output | 1 | Page-table walk pending |
| walk_req_vpn_o | output | 20 | Virtual page number to walk |
| walk_rsp_valid_i | input | 1 | Walk reply present |
| walk_rsp_mapped_i | input | 1 | 1 when the reply carries a mapping |
| walk_rsp_ppn_i | input | 20 | Physical page number of the reply |
| flush_i | input | 1 | Invalidate all lines |

## Verification
A hit is due one edge after the accepting edge, so its result is sampled on the falling edge that follows that edge. A miss shows its walk request at that same point. The reply is then held back for two further cycles to confirm that the request, the page number and the low ready signal all stay put. The translation or fault, together with the return of ready, is sampled on the falling edge after the edge that captured the reply. Replacement order is checked only through hits and misses on later requests, which are told apart by whether a walk request appears.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } xlate_state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [VPN_W-1:0]   lk_vpn_i,
  output logic               hit_o,
  output logic [PPN_W-1:0]   hit_ppn_o,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [VPN_W-1:0]   wr_vpn_i,
  input  logic [PPN_W-1:0]   wr_ppn_i,
  output logic [ENTRIES-1:0] valid_o
);
  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_line
    assign hit_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        vpn_q[g]   <= '0;
        ppn_q[g]   <= '0;
      end else if (flush_i) begin
        valid_q[g] <= 1'b0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        valid_q[g] <= 1'b1;
        vpn_q[g]   <= wr_vpn_i;
        ppn_q[g]   <= wr_ppn_i;
      end
    end
  end

  // OR-reduce the matching line's ppn; at most one line matches
  always_comb begin
    hit_ppn_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_ppn_o = hit_ppn_o | ppn_q[i];
    end
  end

  assign hit_o   = |hit_vec;
  assign valid_o = valid_q;

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R2
  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0)); // R9
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               refill_i,
  output logic [IDX_W-1:0]   victim_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             all_full;

  assign all_full = &valid_i;

  // lowest-indexed invalid line wins
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim_o = all_full ? rr_q : free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (refill_i && all_full) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  AST_VICTIM_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_full |-> !valid_i[victim_o]); // R7
  AST_RR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_q <= IDX_W'(ENTRIES - 1)); // R8
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 32,
  parameter int unsigned PG_OFF_W = 12,
  parameter int unsigned ENTRIES  = 8,
  localparam int unsigned VPN_W   = VA_W - PG_OFF_W,
  localparam int unsigned PPN_W   = PA_W - PG_OFF_W,
  localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o,
  output logic             walk_req_valid_o,
  output logic [VPN_W-1:0] walk_req_vpn_o,
  input  logic             walk_rsp_valid_i,
  input  logic             walk_rsp_mapped_i,
  input  logic [PPN_W-1:0] walk_rsp_ppn_i,
  input  logic             flush_i
);
  xlate_state_e        state_q;
  logic [VPN_W-1:0]    vpn_q;
  logic [PG_OFF_W-1:0] off_q;
  logic                rsp_valid_q, rsp_fault_q;
  logic [PA_W-1:0]     rsp_paddr_q;

  logic                accept, walk_done, refill;
  logic                hit;
  logic [PPN_W-1:0]    hit_ppn;
  logic [ENTRIES-1:0]  valid;
  logic [IDX_W-1:0]    victim;
  logic [VPN_W-1:0]    req_vpn;
  logic [PG_OFF_W-1:0] req_off;

  assign req_vpn     = req_vaddr_i[VA_W-1:PG_OFF_W];
  assign req_off     = req_vaddr_i[PG_OFF_W-1:0];
  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign walk_done   = (state_q == ST_WALK) && walk_rsp_valid_i;
  assign refill      = walk_done && walk_rsp_mapped_i && !flush_i;

  tlb_cam #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) i_cam (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .lk_vpn_i  (req_vpn),
    .hit_o     (hit),
    .hit_ppn_o (hit_ppn),
    .wr_en_i   (refill),
    .wr_idx_i  (victim),
    .wr_vpn_i  (vpn_q),
    .wr_ppn_i  (walk_rsp_ppn_i),
    .valid_o   (valid)
  );

  tlb_victim #(
    .ENTRIES (ENTRIES)
  ) i_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid),
    .refill_i (refill),
    .victim_o (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      vpn_q       <= '0;
      off_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            vpn_q <= req_vpn;
            off_q <= req_off;
            if (hit) begin
              rsp_valid_q <= 1'b1;
              rsp_paddr_q <= {hit_ppn, req_off};
            end else begin
              state_q <= ST_WALK;
            end
          end
        end
        ST_WALK: begin
          if (walk_rsp_valid_i) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            if (walk_rsp_mapped_i) begin
              rsp_paddr_q <= {walk_rsp_ppn_i, off_q};
            end else begin
              rsp_fault_q <= 1'b1;
              rsp_paddr_q <= '0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o      = rsp_valid_q;
  assign rsp_fault_o      = rsp_fault_q;
  assign rsp_paddr_o      = rsp_paddr_q;
  assign walk_req_valid_o = (state_q == ST_WALK);
  assign walk_req_vpn_o   = vpn_q;

  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_paddr_o[PG_OFF_W-1:0] == off_q)); // R1
  AST_WALK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_valid_o && !walk_rsp_valid_i) |=> (walk_req_valid_o && $stable(walk_req_vpn_o))); // R3
  AST_NO_RSP_WHILE_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_valid_o |-> (!rsp_valid_o && !req_ready_o)); // R3
  AST_FAULT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_valid_o && (rsp_paddr_o == '0))); // R5
  AST_WALK_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_valid_o && walk_rsp_valid_i) |=> (rsp_valid_o && req_ready_o)); // R4
endmodule

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        walk_rsp_valid = 1'b0;
  logic        walk_rsp_mapped = 1'b0;
  logic [19:0] walk_rsp_ppn = '0;
  logic        flush = 1'b0;
  logic        req_ready, rsp_valid, rsp_fault, walk_req_valid;
  logic [31:0] rsp_paddr;
  logic [19:0] walk_req_vpn;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_xlate i_tlb_xlate (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .req_valid_i       (req_valid),
    .req_ready_o       (req_ready),
    .req_vaddr_i       (req_vaddr),
    .rsp_valid_o       (rsp_valid),
    .rsp_paddr_o       (rsp_paddr),
    .rsp_fault_o       (rsp_fault),
    .walk_req_valid_o  (walk_req_valid),
    .walk_req_vpn_o    (walk_req_vpn),
    .walk_rsp_valid_i  (walk_rsp_valid),
    .walk_rsp_mapped_i (walk_rsp_mapped),
    .walk_rsp_ppn_i    (walk_rsp_ppn),
    .flush_i           (flush)
  );

  function automatic logic [19:0] map_ppn(logic [19:0] vpn);
    return vpn ^ 20'h5A5A5;
  endfunction

  function automatic bit is_mapped(logic [19:0] vpn);
    return vpn[19:16] != 4'hF;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // issue one translation; exp_hit selects the expected path
  task automatic xlate(logic [31:0] va, bit exp_hit, string req, bit flush_on_rsp = 1'b0);
    logic [19:0] vpn;
    logic [31:0] exp_pa;
    vpn = va[31:12];
    exp_pa = is_mapped(vpn) ? {map_ppn(vpn), va[11:0]} : 32'h0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == exp_hit, req, "hit", 32'(rsp_valid), 32'(exp_hit));
    if (rsp_valid) begin
      chk(rsp_paddr == exp_pa, "R1", "hit paddr", rsp_paddr, exp_pa);
      chk(!walk_req_valid, "R2", "no walk on hit", 32'(walk_req_valid), 32'h0);
    end else begin
      chk(walk_req_valid && !req_ready, "R3", "walk pending", {30'h0, walk_req_valid, req_ready}, 32'h2);
      chk(walk_req_vpn == vpn, "R3", "walk vpn", 32'(walk_req_vpn), 32'(vpn));
      if (!walk_req_valid) return;
      repeat (2) @(negedge clk);
      chk(walk_req_valid && !req_ready && !rsp_valid && walk_req_vpn == vpn, "R3", "walk held",
          {29'h0, walk_req_valid, req_ready, rsp_valid}, 32'h4);
      walk_rsp_valid  = 1'b1;
      walk_rsp_mapped = is_mapped(vpn);
      walk_rsp_ppn    = map_ppn(vpn);
      flush           = flush_on_rsp;
      @(negedge clk);
      walk_rsp_valid = 1'b0;
      flush          = 1'b0;
      chk(rsp_valid && req_ready && !walk_req_valid, "R4", "reply strobe",
          {29'h0, rsp_valid, req_ready, walk_req_valid}, 32'h6);
      chk(rsp_fault == !is_mapped(vpn), "R5", "fault", 32'(rsp_fault), 32'(!is_mapped(vpn)));
      chk(rsp_paddr == exp_pa, is_mapped(vpn) ? "R4" : "R5", "walk paddr", rsp_paddr, exp_pa);
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    chk(req_ready && !rsp_valid && !rsp_fault && !walk_req_valid, "R6", "reset outputs",
        {28'h0, req_ready, rsp_valid, rsp_fault, walk_req_valid}, 32'h8);
  endtask

  task automatic t_miss_then_hit();
    xlate(32'h12345ABC, 1'b0, "R4 first access");
    xlate(32'h12345007, 1'b1, "R2 same page");
    xlate(32'h12345FFF, 1'b1, "R1 top offset");
  endtask

  task automatic t_fault();
    xlate(32'hF0000123, 1'b0, "R5 unmapped");
    xlate(32'hF0000456, 1'b0, "R5 not installed");
  endtask

  task automatic t_fill_and_rotate();
    for (int i = 0; i < 7; i++) xlate({20'h00010 + 20'(i), 12'h010 + 12'(i)}, 1'b0, "R7 fill");
    xlate(32'h12345000, 1'b1, "R7 line0 kept");
    for (int i = 0; i < 7; i++) xlate({20'h00010 + 20'(i), 12'h300}, 1'b1, "R7 all resident");
    xlate(32'h00100AAA, 1'b0, "R8 evict line0");
    xlate(32'h12345111, 1'b0, "R8 line0 gone");
    xlate(32'h00011222, 1'b1, "R8 line2 kept");
    xlate(32'h00010333, 1'b0, "R8 line1 gone");
    xlate(32'h00012444, 1'b1, "R8 line3 kept");
    xlate(32'h00100555, 1'b1, "R8 new page resident");
  endtask

  task automatic t_flush();
    do_flush();
    xlate(32'h00012444, 1'b0, "R9 flushed");
    xlate(32'h00100555, 1'b0, "R9 flushed 2");
    do_flush();
    xlate(32'h0ABCD010, 1'b0, "R9 race", 1'b1);
    xlate(32'h0ABCD020, 1'b0, "R9 refill dropped");
    xlate(32'h0ABCD030, 1'b1, "R9 later refill kept");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_then_hit();
    t_fault();
    t_fill_and_rotate();
    t_flush();
    repeat (2) @(negedge clk);
    report();
  end
endmodule